// File: doc/BRIEF.md
# Cycle-Stealing Block DMA Controller

This controller moves one block of 32-bit words between memory and a byte-wide device without the processor touching each datum. Software writes the direction, the device address, the first memory address and the number of words, then pulses a start strobe. From then on the device hands bytes over through a request/grant pair. The controller borrows single memory cycles from the processor through a second request/grant pair, one cycle per word.

Toward memory, four device bytes are packed into a word before that word is written. Toward the device, a word is read and its bytes are handed out one at a time. After the last word, or after the last byte of the last word, the controller raises a level interrupt. The interrupt stays up until the processor acknowledges it or starts a new block.

Top module: `cyc_dma_ctrl`

## Requirements
- R1: While reset is asserted, and right after it, busy, irq, mcr, dev_gnt and mem_en are all 0.
- R2: A start strobe with a nonzero count makes busy 1 from the next cycle. While busy, dev_sel shows the programmed device address. The first memory access uses the programmed start address.
- R3: With cfg_dir=0 (device to memory), a device request is granted in its own cycle while fewer than three bytes of the current word are held. The word written carries the first byte in bits 31:24, the second in 23:16, the third in 15:8 and the fourth in 7:0.
- R4: With cfg_dir=0, a request for the fourth byte of a word is not granted at once. It raises mcr from the next cycle. In the cycle where mcg is 1, that byte is granted and mem_en=1 with mem_we=1.
- R5: mcr stays 1 until mcg arrives. mem_en is 1 only in a cycle with both mcr and mcg. Each grant causes exactly one access, and mcr is 0 in the following cycle.
- R6: Each access uses an address one above the previous one in the block. The number of accesses in a block equals the programmed count.
- R7: With cfg_dir=1 (memory to device), mcr rises right after start, before any byte is granted. mem_we is 0 on these reads. Bytes go out from bits 7:0 upward. The next word is fetched only after the fourth byte has been granted.
- R8: irq becomes 1 and busy 0 in the cycle after the final word write (cfg_dir=0) or the final byte grant (cfg_dir=1).
- R9: irq stays 1 until a cycle with irq_ack or cfg_start, after which it is 0.
- R10: A start strobe with a zero count sets irq in the next cycle, keeps busy at 0 and never raises mcr.
- R11: mcg while mcr is 0 causes no memory access and no state change.
- R12: A start strobe while busy abandons the current block, including any partly packed word, and runs the newly programmed block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_start | input | 1 | One-cycle strobe that loads the settings and starts a block |
| cfg_dir | input | 1 | 0: device to memory, 1: memory to device |
| cfg_dev_addr | input | DEV_AW | Device address for the block |
| cfg_mem_addr | input | MEM_AW | First word address in memory |
| cfg_word_cnt | input | CNT_W | Number of words in the block |
| irq_ack | input | 1 | Clears the completion interrupt |
| dev_req | input | 1 | Device asks to hand over or take a byte |
| dev_rdata | input | BYTE_W | Byte from the device |
| dev_gnt | output | 1 | Byte accepted from, or offered to, the device in this cycle |
| dev_sel | output | DEV_AW | Selected device address |
| dev_wdata | output | BYTE_W | Byte to the device, valid with dev_gnt |
| mcr | output | 1 | Request for one memory cycle |
| mcg | input | 1 | Processor yields the current memory cycle |
| mem_en | output | 1 | Memory access in this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | MEM_AW | Word address |
| mem_wdata | output | WORD_W | Word to memory |
| mem_rdata | input | WORD_W | Word from memory, valid in the access cycle |
| irq | output | 1 | Block complete, held as a level |
| busy | output | 1 | A block is in progress |

## Verification
The checks assume that a device keeps dev_req high, with dev_rdata steady, until it sees dev_gnt. They also assume that memory returns read data in the same cycle that mem_en is high. The bench device raises a request on a pseudo-random cycle and holds it with fixed data until it is granted. The bench memory answers combinationally with a pattern computed from the address. The processor side grants mcg on pseudo-random cycles while mcr is high. In some phases it also drives stray mcg pulses, which the checks treat as permitted input.

// File: rtl/cdma_pkg.sv
package cdma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MOVE = 2'd1,
    ST_MEM  = 2'd2
  } cdma_state_e;

  localparam logic DIR_TO_MEM = 1'b0;
  localparam logic DIR_TO_DEV = 1'b1;
endpackage

// File: rtl/cdma_regs.sv
// Programmed settings plus the running word address and remaining count.
module cdma_regs #(
  parameter int DEV_AW = 8,
  parameter int MEM_AW = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic              cfg_dir,
  input  logic [DEV_AW-1:0] cfg_dev,
  input  logic [MEM_AW-1:0] cfg_mem,
  input  logic [CNT_W-1:0]  cfg_cnt,
  output logic              dir_q,
  output logic [DEV_AW-1:0] dev_q,
  output logic [MEM_AW-1:0] addr_q,
  output logic              last_word,
  output logic              left_zero
);
  logic              dir_d;
  logic [DEV_AW-1:0] dev_d;
  logic [MEM_AW-1:0] addr_d;
  logic [CNT_W-1:0]  left_q, left_d;
  logic              en;

  assign en        = load | step;
  assign last_word = (left_q == CNT_W'(1));
  assign left_zero = (left_q == '0);

  always_comb begin
    dir_d  = dir_q;
    dev_d  = dev_q;
    addr_d = addr_q;
    left_d = left_q;
    if (load) begin
      dir_d  = cfg_dir;
      dev_d  = cfg_dev;
      addr_d = cfg_mem;
      left_d = cfg_cnt;
    end else if (step) begin
      addr_d = addr_q + 1'b1;
      left_d = left_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= 1'b0;
      dev_q  <= '0;
      addr_q <= '0;
      left_q <= '0;
    end else if (en) begin
      dir_q  <= dir_d;
      dev_q  <= dev_d;
      addr_q <= addr_d;
      left_q <= left_d;
    end
  end
endmodule

// File: rtl/cdma_pack.sv
// Word buffer with byte-lane counter: shifts bytes in (toward memory) or out (toward device).
module cdma_pack #(
  parameter int WORD_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              push,
  input  logic              pop,
  input  logic              load,
  input  logic              store,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic [WORD_W-1:0] word_in,
  output logic [BYTE_W-1:0] byte_out,
  output logic [WORD_W-1:0] word_out,
  output logic              full
);
  localparam int LANES  = WORD_W / BYTE_W;
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;
  localparam logic [LANE_W-1:0] LANE_LAST = LANE_W'(LANES - 1);

  logic [WORD_W-1:0] buf_q, buf_d;
  logic [LANE_W-1:0] lane_q, lane_d;
  logic              en;

  assign en       = clr | push | pop | load | store;
  assign full     = (lane_q == LANE_LAST);
  assign byte_out = buf_q[BYTE_W-1:0];
  assign word_out = {buf_q[WORD_W-BYTE_W-1:0], byte_in};

  always_comb begin
    buf_d  = buf_q;
    lane_d = lane_q;
    if (clr || store) begin
      lane_d = '0;
    end else if (load) begin
      buf_d  = word_in;
      lane_d = '0;
    end else if (push) begin
      buf_d  = {buf_q[WORD_W-BYTE_W-1:0], byte_in};
      lane_d = lane_q + 1'b1;
    end else if (pop) begin
      buf_d  = buf_q >> BYTE_W;
      lane_d = full ? '0 : lane_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q  <= '0;
      lane_q <= '0;
    end else if (en) begin
      buf_q  <= buf_d;
      lane_q <= lane_d;
    end
  end
endmodule

// File: rtl/cdma_fsm.sv
// Transfer sequencing: byte handshakes, memory-cycle borrowing, completion level.
module cdma_fsm
  import cdma_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic start_zero,
  input  logic start_dir,
  input  logic dir_q,
  input  logic dev_req,
  input  logic mcg,
  input  logic lane_full,
  input  logic last_word,
  input  logic left_zero,
  input  logic irq_ack,
  output logic busy,
  output logic mcr,
  output logic dev_gnt,
  output logic mem_en,
  output logic mem_we,
  output logic push,
  output logic pop,
  output logic load_word,
  output logic store,
  output logic step,
  output logic irq
);
  cdma_state_e state_q, state_d;
  logic        irq_q, irq_d;
  logic        done;

  assign busy = (state_q != ST_IDLE);
  assign irq  = irq_q;

  always_comb begin
    state_d   = state_q;
    mcr       = 1'b0;
    dev_gnt   = 1'b0;
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    push      = 1'b0;
    pop       = 1'b0;
    load_word = 1'b0;
    store     = 1'b0;
    step      = 1'b0;
    done      = 1'b0;
    case (state_q)
      ST_MOVE: begin
        if (dev_req) begin
          if (dir_q == DIR_TO_MEM) begin
            if (!lane_full) begin
              dev_gnt = 1'b1;
              push    = 1'b1;
            end else begin
              state_d = ST_MEM;
            end
          end else begin
            dev_gnt = 1'b1;
            pop     = 1'b1;
            if (lane_full) begin
              if (left_zero) begin
                done    = 1'b1;
                state_d = ST_IDLE;
              end else begin
                state_d = ST_MEM;
              end
            end
          end
        end
      end
      ST_MEM: begin
        mcr = 1'b1;
        if (mcg) begin
          mem_en = 1'b1;
          step   = 1'b1;
          if (dir_q == DIR_TO_MEM) begin
            mem_we  = 1'b1;
            dev_gnt = 1'b1;
            store   = 1'b1;
            if (last_word) begin
              done    = 1'b1;
              state_d = ST_IDLE;
            end else begin
              state_d = ST_MOVE;
            end
          end else begin
            load_word = 1'b1;
            state_d   = ST_MOVE;
          end
        end
      end
      default: ;
    endcase
    if (start) begin
      if (start_zero)                state_d = ST_IDLE;
      else if (start_dir == DIR_TO_DEV) state_d = ST_MEM;
      else                           state_d = ST_MOVE;
    end
  end

  always_comb begin
    irq_d = irq_q;
    if (start)        irq_d = start_zero;
    else if (done)    irq_d = 1'b1;
    else if (irq_ack) irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      irq_q   <= irq_d;
    end
  end
endmodule

// File: rtl/cyc_dma_ctrl.sv
module cyc_dma_ctrl #(
  parameter int DEV_AW = 8,
  parameter int MEM_AW = 16,
  parameter int CNT_W  = 16,
  parameter int WORD_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_start,
  input  logic              cfg_dir,
  input  logic [DEV_AW-1:0] cfg_dev_addr,
  input  logic [MEM_AW-1:0] cfg_mem_addr,
  input  logic [CNT_W-1:0]  cfg_word_cnt,
  input  logic              irq_ack,
  input  logic              dev_req,
  input  logic [BYTE_W-1:0] dev_rdata,
  output logic              dev_gnt,
  output logic [DEV_AW-1:0] dev_sel,
  output logic [BYTE_W-1:0] dev_wdata,
  output logic              mcr,
  input  logic              mcg,
  output logic              mem_en,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              irq,
  output logic              busy
);
  logic dir_q, last_word, left_zero, lane_full;
  logic push, pop, load_word, store, step;
  logic cnt_zero;

  assign cnt_zero = (cfg_word_cnt == '0);

  cdma_regs #(.DEV_AW(DEV_AW), .MEM_AW(MEM_AW), .CNT_W(CNT_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (cfg_start),
    .step      (step),
    .cfg_dir   (cfg_dir),
    .cfg_dev   (cfg_dev_addr),
    .cfg_mem   (cfg_mem_addr),
    .cfg_cnt   (cfg_word_cnt),
    .dir_q     (dir_q),
    .dev_q     (dev_sel),
    .addr_q    (mem_addr),
    .last_word (last_word),
    .left_zero (left_zero)
  );

  cdma_pack #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_pack (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (cfg_start),
    .push     (push),
    .pop      (pop),
    .load     (load_word),
    .store    (store),
    .byte_in  (dev_rdata),
    .word_in  (mem_rdata),
    .byte_out (dev_wdata),
    .word_out (mem_wdata),
    .full     (lane_full)
  );

  cdma_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (cfg_start),
    .start_zero (cnt_zero),
    .start_dir  (cfg_dir),
    .dir_q      (dir_q),
    .dev_req    (dev_req),
    .mcg        (mcg),
    .lane_full  (lane_full),
    .last_word  (last_word),
    .left_zero  (left_zero),
    .irq_ack    (irq_ack),
    .busy       (busy),
    .mcr        (mcr),
    .dev_gnt    (dev_gnt),
    .mem_en     (mem_en),
    .mem_we     (mem_we),
    .push       (push),
    .pop        (pop),
    .load_word  (load_word),
    .store      (store),
    .step       (step),
    .irq        (irq)
  );
endmodule

// File: rtl/cdma_chk.sv
module cdma_chk #(
  parameter int MEM_AW = 16,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_start,
  input logic [CNT_W-1:0]  cfg_word_cnt,
  input logic              irq_ack,
  input logic              dev_req,
  input logic              dev_gnt,
  input logic              mcr,
  input logic              mcg,
  input logic              mem_en,
  input logic              mem_we,
  input logic [MEM_AW-1:0] mem_addr,
  input logic              irq,
  input logic              busy
);
  assert_mem_in_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> (mcr && mcg));

  assert_mcr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mcr && !mcg && !cfg_start) |=> mcr);

  assert_mcr_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mcr && mcg && !cfg_start) |=> !mcr);

  assert_gnt_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dev_gnt |-> (dev_req && busy));

  assert_we_in_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_en);

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mcr && !dev_gnt && !mem_en));

  assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !cfg_start) |=> (mem_addr == MEM_AW'($past(mem_addr) + 1'b1)));

  assert_zero_cnt_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_start && cfg_word_cnt == '0) |=> (irq && !busy));

  assert_irq_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_ack && !cfg_start) |=> irq);
endmodule

bind cyc_dma_ctrl cdma_chk #(.MEM_AW(MEM_AW), .CNT_W(CNT_W)) i_chk (.*);

// File: tb/test_cyc_dma_ctrl.sv
`timescale 1ns/1ps
module test_cyc_dma_ctrl;
  logic        clk;
  logic        rst_n;
  logic        cfg_start, cfg_dir, irq_ack, dev_req, mcg;
  logic [7:0]  cfg_dev_addr, dev_rdata;
  logic [15:0] cfg_mem_addr, cfg_word_cnt;
  logic        dev_gnt, mcr, mem_en, mem_we, irq, busy;
  logic [7:0]  dev_sel, dev_wdata;
  logic [15:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;

  int checks = 0, fails = 0, cyc = 0;

  function automatic logic [31:0] rd_pat(input logic [15:0] a);
    return {a[7:0] ^ 8'h3C, a[7:0] + 8'h01, ~a[7:0], a[7:0] ^ 8'hC3};
  endfunction

  assign mem_rdata = rd_pat(mem_addr);

  cyc_dma_ctrl i_cyc_dma_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_dir(cfg_dir),
    .cfg_dev_addr(cfg_dev_addr), .cfg_mem_addr(cfg_mem_addr),
    .cfg_word_cnt(cfg_word_cnt), .irq_ack(irq_ack), .dev_req(dev_req),
    .dev_rdata(dev_rdata), .dev_gnt(dev_gnt), .dev_sel(dev_sel),
    .dev_wdata(dev_wdata), .mcr(mcr), .mcg(mcg), .mem_en(mem_en),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .irq(irq), .busy(busy)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // reference model state
  bit         m_busy, m_fetch, m_dir, m_irq;
  int         m_addr, m_left;
  logic [7:0] m_dev;
  logic [7:0] q[$];

  // agents
  logic [15:0] lfsr = 16'hACE1;
  bit dev_en, spur, req_r;
  int idx = 0, got = 0, wr_cnt = 0, en_cnt = 0;
  logic [15:0] last_wr;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic tick(input bit start, input bit ack);
    bit e_gnt, e_mcr, e_en, e_we, done;
    logic [31:0] w;
    @(negedge clk);
    cfg_start = start;
    irq_ack   = ack;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (!req_r && dev_en && lfsr[0]) req_r = 1'b1;
    dev_req   = req_r;
    dev_rdata = 8'(idx * 37 + 5);
    #1;
    mcg = (mcr && lfsr[3]) || (spur && lfsr[5]);
    #1;
    e_mcr = m_busy && m_fetch;
    e_en  = e_mcr && mcg;
    e_we  = e_en && !m_dir;
    e_gnt = m_busy && dev_req && (!m_dir ? (m_fetch ? mcg : (q.size() < 3)) : !m_fetch);
    chk("R8 busy", busy, m_busy);
    chk("R9 irq", irq, m_irq);
    chk("R4 R7 mcr", mcr, e_mcr);
    chk("R3 dev_gnt", dev_gnt, e_gnt);
    chk("R5 R11 mem_en", mem_en, e_en);
    chk("R4 mem_we", mem_we, e_we);
    if (e_en) chk("R6 mem_addr", mem_addr, 32'(16'(m_addr)));
    if (e_we) chk("R3 word order", mem_wdata, {q[0], q[1], q[2], dev_rdata});
    if (e_gnt && m_dir) chk("R7 byte order", dev_wdata, q[0]);
    if (m_busy) chk("R2 dev_sel", dev_sel, m_dev);
    // model step
    if (start) begin
      m_irq = (cfg_word_cnt == 0); m_dir = cfg_dir; m_dev = cfg_dev_addr;
      m_addr = cfg_mem_addr; m_left = cfg_word_cnt; q.delete();
      m_fetch = cfg_dir; m_busy = (cfg_word_cnt != 0);
    end else begin
      done = 1'b0;
      if (m_busy) begin
        if (!m_dir) begin
          if (m_fetch) begin
            if (mcg) begin
              m_addr++; m_left--; q.delete(); m_fetch = 1'b0;
              if (m_left == 0) begin m_busy = 1'b0; done = 1'b1; end
            end
          end else if (dev_req) begin
            if (q.size() < 3) q.push_back(dev_rdata); else m_fetch = 1'b1;
          end
        end else begin
          if (m_fetch) begin
            if (mcg) begin
              w = rd_pat(16'(m_addr));
              for (int i = 0; i < 4; i++) q.push_back(w[8*i +: 8]);
              m_addr++; m_left--; m_fetch = 1'b0;
            end
          end else if (dev_req) begin
            void'(q.pop_front());
            if (q.size() == 0) begin
              if (m_left == 0) begin m_busy = 1'b0; done = 1'b1; end
              else m_fetch = 1'b1;
            end
          end
        end
      end
      if (done) m_irq = 1'b1;
      else if (ack) m_irq = 1'b0;
    end
    // agent bookkeeping from observed ports
    if (dev_gnt) begin req_r = 1'b0; idx++; got++; end
    if (mem_en) en_cnt++;
    if (mem_en && mem_we) begin wr_cnt++; last_wr = mem_addr; end
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog expired act=%0d exp=<150000", cyc);
      finish_run();
    end
  endtask

  task automatic wait_done();
    for (int i = 0; i < 5000 && !irq; i++) tick(1'b0, 1'b0);
  endtask

  task automatic prog(input bit dir, input logic [7:0] dev, input logic [15:0] a, input logic [15:0] n);
    cfg_dir = dir; cfg_dev_addr = dev; cfg_mem_addr = a; cfg_word_cnt = n;
  endtask

  initial begin
    rst_n = 1'b0; cfg_start = 0; cfg_dir = 0; irq_ack = 0; dev_req = 0; mcg = 0;
    cfg_dev_addr = 0; cfg_mem_addr = 0; cfg_word_cnt = 0; dev_rdata = 0;
    dev_en = 0; spur = 0; req_r = 0;
    m_busy = 0; m_fetch = 0; m_dir = 0; m_irq = 0; m_addr = 0; m_left = 0; m_dev = 0;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", busy, 0);
    chk("R1 irq in reset", irq, 0);
    chk("R1 mcr in reset", mcr, 0);
    chk("R1 gnt/mem_en in reset", {dev_gnt, mem_en}, 0);
    rst_n = 1'b1;
    repeat (3) tick(0, 0);
    chk("R1 quiet after reset", {busy, irq, mcr, mem_en}, 0);

    // device to memory, 3 words
    dev_en = 1; wr_cnt = 0;
    prog(0, 8'h5A, 16'h0010, 16'd3);
    tick(1, 0);
    tick(0, 0);
    chk("R2 busy after start", busy, 1);
    wait_done();
    chk("R6 word count in", wr_cnt, 3);
    chk("R6 last address in", last_wr, 16'h0012);
    chk("R8 done in", {irq, busy}, 2'b10);
    repeat (5) tick(0, 0);
    chk("R9 irq held", irq, 1);
    tick(0, 1); tick(0, 0);
    chk("R9 irq cleared by ack", irq, 0);

    // memory to device, 2 words
    got = 0;
    prog(1, 8'hA3, 16'h0100, 16'd2);
    tick(1, 0);
    wait_done();
    chk("R7 bytes out", got, 8);
    chk("R8 done out", {irq, busy}, 2'b10);
    tick(0, 0);
    // start also clears irq
    prog(1, 8'h11, 16'h0200, 16'd4);
    got = 0;
    tick(1, 0); tick(0, 0);
    chk("R9 irq cleared by start", irq, 0);
    wait_done();
    chk("R7 bytes out long", got, 16);
    tick(0, 1);

    // zero count
    dev_en = 0; en_cnt = 0;
    prog(0, 8'h01, 16'h0300, 16'd0);
    tick(1, 0); tick(0, 0);
    chk("R10 zero count", {irq, busy, mcr}, 3'b100);
    repeat (4) tick(0, 0);
    chk("R10 no access", en_cnt, 0);
    tick(0, 1);

    // stray grants while idle
    spur = 1; en_cnt = 0;
    repeat (20) tick(0, 0);
    chk("R11 stray mcg idle", en_cnt, 0);

    // transfer with stray grants present
    dev_en = 1; wr_cnt = 0;
    prog(0, 8'h7E, 16'h0400, 16'd5);
    tick(1, 0);
    wait_done();
    chk("R11 words with stray mcg", wr_cnt, 5);
    tick(0, 1);
    spur = 0;

    // restart mid-block
    wr_cnt = 0; got = 0;
    prog(0, 8'h22, 16'h0020, 16'd2);
    tick(1, 0);
    for (int i = 0; i < 2000 && got < 2; i++) tick(0, 0);
    prog(0, 8'h33, 16'h0040, 16'd1);
    tick(1, 0);
    wait_done();
    chk("R12 writes after restart", wr_cnt, 1);
    chk("R12 restart address", last_wr, 16'h0040);
    tick(0, 1);
    repeat (3) tick(0, 0);

    finish_run();
  end
endmodule